// File: doc/BRIEF.md
# Zero-Test Skip and Literal-XOR Execution Slice

This block is one execution slice of an 8-bit accumulator machine. It handles two single-word instructions: a register zero test that, when the register is zero, throws away the instruction that fetch has already brought in, and an exclusive-OR of an 8-bit literal into the working register W. Each instruction cycle takes four clocks, called phases Q1 to Q4. The current phase is exported so that fetch and the data memory can stay in step with it.

The instruction word is sampled at the end of Q1. For a zero test, the block drives a 12-bit data-memory address and a read strobe during Q2. The memory returns the byte one clock later, during Q3. The result is committed at the end of Q4. When a skip is taken, the following instruction cycle runs as a forced NOP and `squash` is high for it. If fetch predecode reports that the discarded word starts a two-word instruction, a second forced NOP cycle follows, and `stall` is high for that cycle as well as `squash`. Opcodes other than the two handled here take one cycle and have no effect.

Top module: `skipxor_unit`

## Requirements
- R1: While `rst` is high at a clock edge, that edge leaves W=0, `n_flag`=0, `z_flag`=0, `squash`=0, `stall`=0, `dm_rd`=0 and `q_phase`=0 (Q1).
- R2: `q_phase` steps through 0,1,2,3 (Q1..Q4) and then back to 0, advancing by one on every clock edge after reset.
- R3: The word 0000_1010_kkkk_kkkk (bits 15:8 = 0x0A) replaces W with W XOR k. The new W is visible from the first clock of the next Q1. For example, W=0xB5 with k=0xAF gives 0x1A.
- R4: After the XOR, `z_flag` is 1 exactly when the result is 0x00, and `n_flag` equals bit 7 of the result.
- R5: The zero-test word 0110_011a_ffff_ffff (bits 15:9 = 0110011, a = bit 8, f = bits 7:0) changes none of W, `n_flag` or `z_flag`.
- R6: A zero test drives `dm_rd` high for exactly one clock, during Q2, and `dm_addr` is valid at that time. With a=1 the address is {`bsr`, f}. With a=0 it is {4'h0, f} when f < 0x80 and {4'hF, f} when f >= 0x80, whatever the value of `bsr`.
- R7: When the byte read for a zero test is 0x00, the next instruction cycle is a forced NOP. `squash` is high for all four of its phases, the word presented in it has no effect, and normal execution resumes in the cycle after it.
- R8: When the byte read is not zero, no cycle is squashed and the next word executes normally.
- R9: If `pf_two_word` is high at the end of Q4 of a zero test that skips, a second forced NOP cycle follows the first, with `squash` and `stall` both high. `stall` stays low in the first NOP cycle. `pf_two_word` has no effect when no skip is taken.
- R10: Any other opcode takes one instruction cycle, performs no memory read and leaves W, `n_flag` and `z_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction word presented by fetch, sampled at the end of Q1 |
| pf_two_word | input | 1 | Predecode flag: the prefetched word starts a two-word instruction, sampled at the end of Q4 |
| bsr | input | 4 | Bank-select register value |
| dm_addr | output | 12 | Data-memory read address |
| dm_rd | output | 1 | Data-memory read strobe, high in Q2 |
| dm_rdata | input | 8 | Data-memory read byte, valid in Q3 |
| w_out | output | 8 | Working register |
| n_flag | output | 1 | Negative flag |
| z_flag | output | 1 | Zero flag |
| squash | output | 1 | Current instruction cycle is a forced NOP |
| stall | output | 1 | Current cycle is the extra NOP for a two-word skip |
| q_phase | output | 2 | Current phase, 0..3 for Q1..Q4 |

## Verification
The bench checks the boundary of the access-bank split at f=0x80 while a non-zero `bsr` is held. A decoder that honoured `bsr` with a=0, or that split the address at the wrong bit, would read the wrong location and then skip, or fail to skip, at the wrong point. Skips are tested both with and without the two-word flag, and the flag is also raised on a zero test that does not skip. A design that counted NOP cycles wrongly, raised `stall` in the first NOP, or let a squashed XOR change W would show up in the W value or the squash pattern. Opcodes that sit one bit away from both encodings confirm that a decoder that is too loose neither reads memory nor writes W.

// File: rtl/skx_pkg.sv
package skx_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;
  localparam int unsigned IW = 16;
  localparam logic [6:0] OPC_TST = 7'b0110011;
  localparam logic [7:0] OPC_XOR = 8'h0A;
endpackage

// File: rtl/skx_phase_gen.sv
module skx_phase_gen
  import skx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_Q1;
    else     phase <= phase_e'(phase + 2'd1);
  end
endmodule

// File: rtl/skx_decode.sv
module skx_decode
  import skx_pkg::*;
#(
  parameter int unsigned FW = 8,
  parameter int unsigned BW = 4,
  parameter int unsigned DW = 8
) (
  input  logic [IW-1:0]    instr,
  input  logic [BW-1:0]    bsr,
  output logic             is_tst,
  output logic             is_xor,
  output logic [BW+FW-1:0] addr,
  output logic [DW-1:0]    lit
);
  logic          acc_sel_n;
  logic [FW-1:0] fld;
  logic [BW-1:0] acc_bank;

  assign is_tst    = (instr[15:9] == OPC_TST);
  assign is_xor    = (instr[15:8] == OPC_XOR);
  assign acc_sel_n = instr[8];
  assign fld       = instr[FW-1:0];
  assign lit       = instr[DW-1:0];
  // low half of the access window maps to bank 0, upper half to the top bank
  assign acc_bank  = {BW{fld[FW-1]}};
  assign addr      = acc_sel_n ? {bsr, fld} : {acc_bank, fld};
endmodule

// File: rtl/skx_alu.sv
module skx_alu #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] lit,
  input  logic [DW-1:0] mem_byte,
  output logic [DW-1:0] xor_res,
  output logic          mem_zero
);
  assign xor_res  = w_in ^ lit;
  assign mem_zero = (mem_byte == '0);
endmodule

// File: rtl/skipxor_unit.sv
module skipxor_unit
  import skx_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned FW = 8,
  parameter int unsigned BW = 4,
  localparam int unsigned AW = BW + FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   instr_word,
  input  logic          pf_two_word,
  input  logic [BW-1:0] bsr,
  output logic [AW-1:0] dm_addr,
  output logic          dm_rd,
  input  logic [DW-1:0] dm_rdata,
  output logic [DW-1:0] w_out,
  output logic          n_flag,
  output logic          z_flag,
  output logic          squash,
  output logic          stall,
  output logic [1:0]    q_phase
);
  phase_e        phase;
  logic          dec_tst, dec_xor;
  logic [AW-1:0] dec_addr;
  logic [DW-1:0] dec_lit;
  logic          ir_tst, ir_xor;
  logic [DW-1:0] lit_q, res_q, alu_res;
  logic          zero_q, alu_zero, pend_two;

  skx_phase_gen u_phase (.clk(clk), .rst(rst), .phase(phase));

  skx_decode #(.FW(FW), .BW(BW), .DW(DW)) u_dec (
    .instr(instr_word), .bsr(bsr), .is_tst(dec_tst), .is_xor(dec_xor),
    .addr(dec_addr), .lit(dec_lit)
  );

  skx_alu #(.DW(DW)) u_alu (
    .w_in(w_out), .lit(lit_q), .mem_byte(dm_rdata),
    .xor_res(alu_res), .mem_zero(alu_zero)
  );

  assign q_phase = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_tst   <= 1'b0;
      ir_xor   <= 1'b0;
      lit_q    <= '0;
      res_q    <= '0;
      zero_q   <= 1'b0;
      dm_addr  <= '0;
      dm_rd    <= 1'b0;
      w_out    <= '0;
      n_flag   <= 1'b0;
      z_flag   <= 1'b0;
      squash   <= 1'b0;
      stall    <= 1'b0;
      pend_two <= 1'b0;
    end else begin
      unique case (phase)
        PH_Q1: begin
          if (squash) begin
            ir_tst <= 1'b0;
            ir_xor <= 1'b0;
            dm_rd  <= 1'b0;
          end else begin
            ir_tst  <= dec_tst;
            ir_xor  <= dec_xor;
            lit_q   <= dec_lit;
            dm_addr <= dec_addr;
            dm_rd   <= dec_tst;
          end
        end
        PH_Q2: dm_rd <= 1'b0;
        PH_Q3: begin
          res_q  <= alu_res;
          zero_q <= alu_zero;
        end
        PH_Q4: begin
          if (ir_xor) begin
            w_out  <= res_q;
            n_flag <= res_q[DW-1];
            z_flag <= (res_q == '0);
          end
          if (ir_tst && zero_q) begin
            squash   <= 1'b1;
            stall    <= 1'b0;
            pend_two <= pf_two_word;
          end else if (squash && pend_two) begin
            squash   <= 1'b1;
            stall    <= 1'b1;
            pend_two <= 1'b0;
          end else begin
            squash   <= 1'b0;
            stall    <= 1'b0;
            pend_two <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/skx_checker.sv
module skx_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    q_phase,
  input logic          squash,
  input logic          stall,
  input logic          dm_rd,
  input logic [DW-1:0] w_out,
  input logic          n_flag,
  input logic          z_flag
);
  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q_phase == $past(q_phase) + 2'd1);

  p_rd_in_q2_r6: assert property (@(posedge clk) disable iff (rst)
    dm_rd |-> (q_phase == 2'd1) && !squash);

  p_stall_needs_squash_r9: assert property (@(posedge clk) disable iff (rst)
    stall |-> squash);

  p_squash_whole_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (q_phase != 2'd0) |-> $stable(squash) && $stable(stall));

  p_w_only_at_q1_r3: assert property (@(posedge clk) disable iff (rst)
    (q_phase != 2'd0) |-> $stable(w_out));

  p_nop_keeps_w_r7: assert property (@(posedge clk) disable iff (rst)
    (squash && q_phase == 2'd0) |-> $stable(w_out) && $stable(z_flag));

  p_flags_track_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(w_out) |-> (z_flag == (w_out == '0)) && (n_flag == w_out[DW-1]));
endmodule

bind skipxor_unit skx_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .q_phase(q_phase), .squash(squash), .stall(stall),
  .dm_rd(dm_rd), .w_out(w_out), .n_flag(n_flag), .z_flag(z_flag)
);

// File: tb/tb_skipxor_unit.sv
`timescale 1ns/1ps
module tb_skipxor_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_word = 16'h0000;
  logic        pf_two_word = 1'b0;
  logic [3:0]  bsr = 4'h0;
  logic [11:0] dm_addr;
  logic        dm_rd;
  logic [7:0]  dm_rdata = 8'h00;
  logic [7:0]  w_out;
  logic        n_flag, z_flag, squash, stall;
  logic [1:0]  q_phase;

  logic [7:0]  mem [0:4095];
  int          checks = 0, fails = 0, rd_cyc = 0;
  logic [11:0] last_addr = 12'h000;
  logic        sq_seen, st_seen, done = 1'b0;

  always #4 clk = ~clk;

  skipxor_unit dut (
    .clk(clk), .rst(rst), .instr_word(instr_word), .pf_two_word(pf_two_word),
    .bsr(bsr), .dm_addr(dm_addr), .dm_rd(dm_rd), .dm_rdata(dm_rdata),
    .w_out(w_out), .n_flag(n_flag), .z_flag(z_flag), .squash(squash),
    .stall(stall), .q_phase(q_phase)
  );

  always @(posedge clk) begin
    if (dm_rd) begin
      dm_rdata  <= mem[dm_addr];
      last_addr <= dm_addr;
      rd_cyc    <= rd_cyc + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a negedge in Q1; returns at the negedge of the next Q1.
  task automatic exec(input logic [15:0] word, input logic two);
    sq_seen     = squash;
    st_seen     = stall;
    rd_cyc      = 0;
    instr_word  = word;
    pf_two_word = two;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(w_out == 8'h00, "R1 w", w_out, 0);
    chk({n_flag, z_flag} == 2'b00, "R1 flags", {n_flag, z_flag}, 0);
    chk({squash, stall, dm_rd} == 3'b000, "R1 ctl", {squash, stall, dm_rd}, 0);
    chk(q_phase == 2'd0, "R1 phase", q_phase, 0);
  endtask

  task automatic t_phase;
    for (int i = 0; i < 4; i++) begin
      chk(q_phase == 2'(i), "R2 phase", q_phase, i);
      @(negedge clk);
    end
    chk(q_phase == 2'd0, "R2 wrap", q_phase, 0);
  endtask

  task automatic t_xor;
    exec(16'h0AB5, 1'b0);
    chk(w_out == 8'hB5, "R3 w", w_out, 8'hB5);
    chk(n_flag && !z_flag, "R4 n set", {n_flag, z_flag}, 2'b10);
    exec(16'h0AAF, 1'b0);
    chk(w_out == 8'h1A, "R3 example", w_out, 8'h1A);
    chk(!n_flag && !z_flag, "R4 clear", {n_flag, z_flag}, 2'b00);
    exec(16'h0A1A, 1'b0);
    chk(w_out == 8'h00, "R3 to zero", w_out, 0);
    chk(!n_flag && z_flag, "R4 z set", {n_flag, z_flag}, 2'b01);
  endtask

  task automatic t_tst_nonzero;
    mem[12'h005] = 8'h33;
    exec(16'h6605, 1'b1);
    chk(rd_cyc == 1, "R6 one read", rd_cyc, 1);
    chk(last_addr == 12'h005, "R6 low access", last_addr, 12'h005);
    chk(w_out == 8'h00 && z_flag && !n_flag, "R5 no change", {w_out, n_flag, z_flag}, 9'h001);
    exec(16'h0A01, 1'b0);
    chk(!sq_seen, "R8 no squash", sq_seen, 0);
    chk(!sq_seen, "R9 flag ignored without skip", sq_seen, 0);
    chk(w_out == 8'h01, "R8 next runs", w_out, 8'h01);
  endtask

  task automatic t_tst_zero;
    bsr = 4'h3;
    mem[12'hF90] = 8'h00;
    exec(16'h6690, 1'b0);
    chk(last_addr == 12'hF90, "R6 high access ignores bsr", last_addr, 12'hF90);
    exec(16'h0AFF, 1'b0);
    chk(sq_seen && !st_seen, "R7 one nop", {sq_seen, st_seen}, 2'b10);
    chk(rd_cyc == 0, "R7 no read", rd_cyc, 0);
    chk(w_out == 8'h01, "R7 discarded", w_out, 8'h01);
    exec(16'h0A0F, 1'b0);
    chk(!sq_seen, "R7 resume", sq_seen, 0);
    chk(w_out == 8'h0E, "R7 resumed xor", w_out, 8'h0E);
  endtask

  task automatic t_bank_two_word;
    bsr = 4'h5;
    mem[12'h010] = 8'h77;
    mem[12'h510] = 8'h00;
    exec(16'h6710, 1'b1);
    chk(last_addr == 12'h510, "R6 bsr bank", last_addr, 12'h510);
    exec(16'h0A80, 1'b0);
    chk(sq_seen && !st_seen, "R9 first nop", {sq_seen, st_seen}, 2'b10);
    exec(16'h0A80, 1'b0);
    chk(sq_seen && st_seen, "R9 second nop", {sq_seen, st_seen}, 2'b11);
    chk(w_out == 8'h0E, "R9 both discarded", w_out, 8'h0E);
    exec(16'h0A80, 1'b0);
    chk(!sq_seen && !st_seen, "R9 resume", {sq_seen, st_seen}, 0);
    chk(w_out == 8'h8E && n_flag, "R9 resumed xor", w_out, 8'h8E);
    exec(16'h6610, 1'b0);
    chk(last_addr == 12'h010, "R6 a=0 ignores bsr", last_addr, 12'h010);
    exec(16'h0A0E, 1'b0);
    chk(!sq_seen && w_out == 8'h80, "R8 access nonzero", w_out, 8'h80);
  endtask

  task automatic t_unknown;
    logic [15:0] ops [3];
    ops[0] = 16'h1234; ops[1] = 16'h0B55; ops[2] = 16'h6455;
    for (int i = 0; i < 3; i++) begin
      exec(ops[i], 1'b1);
      chk(rd_cyc == 0, "R10 no read", rd_cyc, 0);
      chk(w_out == 8'h80 && n_flag && !z_flag, "R10 state kept", w_out, 8'h80);
    end
    exec(16'h0000, 1'b0);
    chk(!sq_seen, "R10 no squash", sq_seen, 0);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_phase();
    t_xor();
    t_tst_nonzero();
    t_tst_zero();
    t_bank_two_word();
    t_unknown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule